// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit offset into a 20-bit physical address by adding it to a segment base, where the base is a 16-bit segment value shifted left by four bits. It holds four segment registers (code, data, extra and stack), and any of them can be loaded through a write port. Each access request carries an access kind. The block uses that kind to pick the segment that applies by default: code for instruction fetches, data for ordinary operands, extra for string destinations, and stack for accesses made through the stack pointer or the base pointer. A qualified override input can name any of the four segments instead of the default.

The physical address is registered, and so are the start and end addresses of the segment that was used. All three appear one cycle after the request, together with a valid flag. The address space is limited to 1 MiB, so every sum wraps modulo 2^20.

Top module: `segAddrGen`

## Requirements
- R1: After reset all four segment registers hold 0000h, `outValid` is 0, and `physAddr`, `segStart` and `segEnd` are zero.
- R2: A request with `accValid` high produces `outValid` high on the next cycle. In that cycle `physAddr` equals (segment × 16 + offset) mod 2^20.
- R3: Along with each result, `segStart` equals the segment value × 16 and `segEnd` equals (`segStart` + FFFFh) mod 2^20. Segment 1000h with offset F000h gives 1F000h.
- R4: Access kind 0 (instruction fetch) uses the code segment when no override is given.
- R5: Access kind 1 (data) uses the data segment, and kind 2 (string destination) uses the extra segment. The unused kinds 5 to 7 also use the data segment.
- R6: Access kind 3 (through the stack pointer) and kind 4 (through the base pointer) both use the stack segment.
- R7: When `ovrValid` is high, `ovrSel` picks the segment whatever the access kind. The select encoding is 0 code, 1 data, 2 extra, 3 stack, and the same encoding applies to `wrSel`.
- R8: A segment write made with `wrEn` in cycle N is seen by accesses requested from cycle N+1 on. An access requested in cycle N itself still uses the old value.
- R9: A base plus offset that passes FFFFFh wraps. For example, segment FFFFh with offset FFFFh gives 0FFEFh, and segment end addresses wrap the same way.
- R10: A cycle with `accValid` low gives `outValid` low on the next cycle, and the three address outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Segment register write strobe |
| wrSel | input | 2 | Segment register to write |
| wrData | input | 16 | New segment value |
| accValid | input | 1 | Access request qualifier |
| accKind | input | 3 | Access kind code |
| offset | input | 16 | Offset within the segment |
| ovrValid | input | 1 | Segment override qualifier |
| ovrSel | input | 2 | Override segment select |
| outValid | output | 1 | Result valid, one cycle after the request |
| physAddr | output | 20 | Physical address |
| segStart | output | 20 | First address of the segment used |
| segEnd | output | 20 | Last address of the segment used |

## Verification
A corrupted segment register, or a wrong choice of default segment, shows up on the very next result. `segStart` exposes the selected segment value directly, and `physAddr` moves by the same error. A write that lands in the wrong register, or lands a cycle late, only shows when that register is next read. For this reason the bench sweeps every access kind against every segment right after each set of writes, and it also probes the cycle in which a write and a read collide.

// File: rtl/segAddrPkg.sv
package segAddrPkg;

  typedef enum logic [1:0] {
    SEG_CODE  = 2'd0,
    SEG_DATA  = 2'd1,
    SEG_EXTRA = 2'd2,
    SEG_STACK = 2'd3
  } segSel_e;

  typedef enum logic [2:0] {
    ACC_FETCH   = 3'd0,
    ACC_DATA    = 3'd1,
    ACC_STRDST  = 3'd2,
    ACC_STK_SP  = 3'd3,
    ACC_STK_BP  = 3'd4
  } accKind_e;

  localparam int NUM_SEG = 4;

  // control-to-datapath strobes
  typedef struct packed {
    logic    wrStb;
    segSel_e wrTgt;
    logic    rdStb;
    segSel_e rdTgt;
  } ctlStrobe_t;

endpackage

// File: rtl/segAddrCtl.sv
module segAddrCtl
  import segAddrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       accValid,
  input  logic [2:0] accKind,
  input  logic       ovrValid,
  input  logic [1:0] ovrSel,
  output ctlStrobe_t strobe
);

  segSel_e defaultSeg;

  // default segment from the access kind
  always_comb begin
    unique case (accKind)
      ACC_FETCH:              defaultSeg = SEG_CODE;
      ACC_STRDST:             defaultSeg = SEG_EXTRA;
      ACC_STK_SP, ACC_STK_BP: defaultSeg = SEG_STACK;
      default:                defaultSeg = SEG_DATA;
    endcase
  end

  always_comb begin
    strobe.wrStb = wrEn;
    strobe.wrTgt = segSel_e'(wrSel);
    strobe.rdStb = accValid;
    strobe.rdTgt = ovrValid ? segSel_e'(ovrSel) : defaultSeg;
  end

  assert_override_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && ovrValid) |-> (strobe.rdTgt == segSel_e'(ovrSel)));

  assert_fetch_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !ovrValid && accKind == 3'd0) |-> (strobe.rdTgt == SEG_CODE));

  assert_stack_kinds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !ovrValid && (accKind == 3'd3 || accKind == 3'd4))
      |-> (strobe.rdTgt == SEG_STACK));

endmodule

// File: rtl/segAddrDp.sv
module segAddrDp
  import segAddrPkg::*;
#(
  parameter int SEG_W = 16,
  parameter int OFS_W = 16,
  parameter int SHIFT = 4
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [SEG_W-1:0] wrData,
  input  logic [OFS_W-1:0] offset,
  output logic             outValid,
  output logic [SEG_W+SHIFT-1:0] physAddr,
  output logic [SEG_W+SHIFT-1:0] segStart,
  output logic [SEG_W+SHIFT-1:0] segEnd
);

  localparam int PA_W = SEG_W + SHIFT;
  localparam logic [PA_W-1:0] SPAN = PA_W'((64'd1 << OFS_W) - 64'd1);

  logic [SEG_W-1:0] segRegs [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        segRegs[i] <= '0;
      else if (strobe.wrStb && strobe.wrTgt == segSel_e'(i))
        segRegs[i] <= wrData;
    end

    assert_write_lands_R8: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrStb && strobe.wrTgt == segSel_e'(i)) |=> (segRegs[i] == $past(wrData)));
  end

  logic [SEG_W-1:0] selSeg;
  logic [PA_W-1:0]  baseNext, physNext, endNext;

  always_comb begin
    selSeg   = segRegs[strobe.rdTgt];
    baseNext = {selSeg, {SHIFT{1'b0}}};
    physNext = baseNext + PA_W'(offset);
    endNext  = baseNext + SPAN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      physAddr <= '0;
      segStart <= '0;
      segEnd   <= '0;
    end else begin
      outValid <= strobe.rdStb;
      if (strobe.rdStb) begin
        physAddr <= physNext;
        segStart <= baseNext;
        segEnd   <= endNext;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStb |=> outValid);

  assert_offset_span_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdStb |=> (PA_W'(physAddr - segStart) == PA_W'($past(offset))));

  assert_start_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (segStart[SHIFT-1:0] == '0));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdStb |=> (!outValid && $stable(physAddr) && $stable(segEnd)));

endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segAddrPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [15:0] wrData,
  input  logic        accValid,
  input  logic [2:0]  accKind,
  input  logic [15:0] offset,
  input  logic        ovrValid,
  input  logic [1:0]  ovrSel,
  output logic        outValid,
  output logic [19:0] physAddr,
  output logic [19:0] segStart,
  output logic [19:0] segEnd
);

  ctlStrobe_t strobe;

  segAddrCtl u_ctl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel),
    .accValid(accValid), .accKind(accKind),
    .ovrValid(ovrValid), .ovrSel(ovrSel), .strobe(strobe)
  );

  segAddrDp #(.SEG_W(16), .OFS_W(16), .SHIFT(4)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .offset(offset), .outValid(outValid), .physAddr(physAddr),
    .segStart(segStart), .segEnd(segEnd)
  );

endmodule

// File: tb/sim_segAddrGen.sv
module sim_segAddrGen;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic wrEn = 0; logic [1:0] wrSel = 0; logic [15:0] wrData = 0;
  logic accValid = 0; logic [2:0] accKind = 0; logic [15:0] offset = 0;
  logic ovrValid = 0; logic [1:0] ovrSel = 0;
  logic outValid; logic [19:0] physAddr, segStart, segEnd;

  int checks = 0, errors = 0;
  logic [15:0] model [4];
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segAddrGen u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] pickSeg(input logic [2:0] k, input logic ov, input logic [1:0] os);
    if (ov) return os;
    case (k)
      3'd0: return 2'd0;
      3'd2: return 2'd2;
      3'd3, 3'd4: return 2'd3;
      default: return 2'd1;
    endcase
  endfunction

  task automatic writeSeg(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk); wrEn = 1; wrSel = s; wrData = v;
    @(negedge clk); wrEn = 0; model[s] = v;
  endtask

  task automatic access(input string req, input logic [2:0] k, input logic [15:0] o,
                        input logic ov, input logic [1:0] os);
    logic [19:0] base, expPhys;
    base = {model[pickSeg(k, ov, os)], 4'h0};
    expPhys = base + {4'h0, o};
    @(negedge clk); accValid = 1; accKind = k; offset = o; ovrValid = ov; ovrSel = os;
    @(negedge clk); accValid = 0; ovrValid = 0;
    check(req, {31'd0, outValid}, 32'd1);
    check(req, {12'd0, physAddr}, {12'd0, expPhys});
    check("R3 start", {12'd0, segStart}, {12'd0, base});
    check("R3 end", {12'd0, segEnd}, {12'd0, base + 20'h0FFFF});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = 16'h0;
    #(CLK_PERIOD * 3);
    // R1: reset state
    check("R1 valid", {31'd0, outValid}, 32'd0);
    check("R1 phys", {12'd0, physAddr}, 32'd0);
    check("R1 end", {12'd0, segEnd}, 32'd0);
    @(negedge clk); rstN = 1;
    access("R1 zero segs", 3'd1, 16'h1234, 1'b0, 2'd0);

    // R3: worked example
    writeSeg(2'd1, 16'h1000);
    access("R3 example", 3'd1, 16'hF000, 1'b0, 2'd0);
    check("R3 example", {12'd0, physAddr}, 32'h1F000);

    // sweep segment sets x kinds x overrides x offsets (R2 R4 R5 R6 R7)
    for (int set = 0; set < 6; set++) begin
      for (int s = 0; s < 4; s++)
        writeSeg(2'(s), 16'(set * 16'h2F31 + s * 16'h1111 + (set == 5 ? 16'hF000 : 16'h0)));
      for (int k = 0; k < 8; k++) begin
        for (int ov = 0; ov < 5; ov++) begin
          for (int o = 0; o < 4; o++) begin
            logic [15:0] ofs;
            ofs = (o == 0) ? 16'h0000 : (o == 1) ? 16'hFFFF : 16'(o * 16'h3A5B + k);
            access(k == 0 ? "R4 fetch" : (k == 3 || k == 4) ? "R6 stack" :
                   ov < 4 ? "R7 override" : "R5 data/extra",
                   3'(k), ofs, ov < 4, 2'(ov));
          end
        end
      end
    end

    // R9: wrap beyond 1 MiB
    writeSeg(2'd3, 16'hFFFF);
    access("R9 wrap", 3'd3, 16'hFFFF, 1'b0, 2'd0);
    check("R9 wrap", {12'd0, physAddr}, 32'h0FFEF);
    check("R9 end wrap", {12'd0, segEnd}, 32'h0FFEF);

    // R8: write and access in the same cycle sees the old value
    writeSeg(2'd1, 16'h2000);
    @(negedge clk);
    wrEn = 1; wrSel = 2'd1; wrData = 16'h3000;
    accValid = 1; accKind = 3'd1; offset = 16'h0010; ovrValid = 0;
    @(negedge clk);
    wrEn = 0; model[1] = 16'h3000;
    check("R8 old value", {12'd0, physAddr}, 32'h20010);
    @(negedge clk); accValid = 0;
    check("R8 new value", {12'd0, physAddr}, 32'h30010);

    // R10: idle cycle holds outputs and drops valid
    access("R10 setup", 3'd0, 16'h0042, 1'b0, 2'd0);
    @(negedge clk); accValid = 0; offset = 16'hBEEF; accKind = 3'd1;
    @(negedge clk);
    check("R10 valid low", {31'd0, outValid}, 32'd0);
    check("R10 phys held", {12'd0, physAddr}, {12'd0, {model[0], 4'h0} + 20'h00042});

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule